// File: doc/BRIEF.md
# DDR SDRAM Transaction Command Sequencer

This block drives the command and address pins of a DDR SDRAM device for one read or write transaction at a time. A transaction names a direction, a bank, a row, a starting column and an even count of data words. The sequencer compares the request with the row it remembers as open in that bank. The result selects one of three starting points. A different open row starts with a single-bank precharge. A closed bank starts with an activate. A matching open row starts directly with the column commands.

Spacings between commands come from programmable fields. These are the precharge-to-activate gap, the activate-to-column gap, write recovery and the minimum activate-to-precharge time. Each column command moves one pair of data words, so a request issues half as many column commands as it has words. Chip select is held low from the first command until one idle cycle after the last column command. When auto-precharge is enabled, only the final column command carries the auto-precharge address bit. The bank tracker then marks that bank closed.

Top module: `ddr_txn_seq`

## Requirements
- R1: After reset, chip select is high, {ras_n, cas_n, we_n} is 111 (NOP), busy is low, and every bank is treated as closed, so the first access to any bank starts with an activate.
- R2: On a row mismatch, the first command is PRECHARGE (010) to the requested bank with the auto-precharge address bit low. ACTIVE (011) follows exactly cfg_rp cycles later with the row on addr. The cycles between them carry NOP with chip select low, and there are none when cfg_rp is 1.
- R3: When the requested bank has no open row, the first command is ACTIVE with the row on addr, issued on the cycle after the request is accepted.
- R4: When the requested row is already open, the first command is the column command, issued on the cycle after the request is accepted.
- R5: The first column command comes exactly cfg_rcd cycles after ACTIVE, with NOP and chip select low in between, and no NOP when cfg_rcd is 1.
- R6: A request of N words issues N/2 back-to-back column commands, READ (101) or WRITE (100), to the requested bank. Command i carries column req_col + 2*i in the low addr bits.
- R7: With cfg_ap_en set, only the last column command of the transaction has addr bit AP_BIT (10 by default) high. With cfg_ap_en clear, no column command has that bit high.
- R8: The open-row record of a bank is cleared by a PRECHARGE or an auto-precharged column command and is set to the row by ACTIVE. An access after an auto-precharge therefore starts with ACTIVE.
- R9: A PRECHARGE to a bank is not issued earlier than cfg_atp cycles after that bank's ACTIVE. Chip select stays high while it waits.
- R10: A PRECHARGE to a bank is not issued earlier than cfg_wr + 1 cycles after a WRITE to that bank.
- R11: Chip select is low from the first command to the NOP on the cycle after the last column command, then returns high. Every cycle with chip select high shows NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when busy is low |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Starting column |
| req_words | input | WORDS_W | Number of data words, even and at least 2 |
| cfg_rp | input | CFG_W | Precharge-to-activate gap, 1 to 4 |
| cfg_rcd | input | CFG_W | Activate-to-column gap, 1 to 4 |
| cfg_wr | input | CFG_W | Write recovery, 1 to 4 |
| cfg_atp | input | ATP_W | Minimum activate-to-precharge time, 5 to 8 |
| cfg_ap_en | input | 1 | Auto-precharge on the last column command |
| busy | output | 1 | A transaction is in progress |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ROW_W | Row, column and auto-precharge address bit |

## Verification
The assertions assume the timing fields stay within their legal ranges and do not change while a transaction is in progress. They also assume every request asks for an even word count of at least two. The spacing checks read the fields live, so a change mid-transaction would be flagged wrongly. The bench writes the fields only while the block is idle, before it raises req_valid. It takes its word counts and field values from the legal sets.

// File: rtl/ddr_seq_pkg.sv
package ddr_seq_pkg;

    // {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_NOP = 3'b111
    } ddr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WACT,
        ST_WCOL,
        ST_COL,
        ST_TAIL
    } seq_st_e;

endpackage

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot
    import ddr_seq_pkg::*;
#(
    parameter int ROW_W = 13,
    parameter int CFG_W = 3,
    parameter int ATP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_sel,
    input  ddr_cmd_e         evt_cmd,
    input  logic [ROW_W-1:0] evt_row,
    input  logic             evt_ap,
    input  logic [ATP_W-1:0] cfg_atp,
    input  logic [CFG_W-1:0] cfg_wr,
    output logic             open_vld,
    output logic [ROW_W-1:0] open_row,
    output logic             pre_ok
);

    typedef struct packed {
        logic             vld;
        logic [ROW_W-1:0] row;
        logic [ATP_W-1:0] ras;
        logic [CFG_W-1:0] wrc;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.ras != '0) slot_d.ras = slot_q.ras - 1'b1;
        if (slot_q.wrc != '0) slot_d.wrc = slot_q.wrc - 1'b1;
        if (evt_sel) begin
            case (evt_cmd)
                CMD_ACT: begin
                    slot_d.vld = 1'b1;
                    slot_d.row = evt_row;
                    slot_d.ras = cfg_atp - 1'b1;
                end
                CMD_PRE: slot_d.vld = 1'b0;
                CMD_WR: begin
                    slot_d.wrc = cfg_wr;
                    if (evt_ap) slot_d.vld = 1'b0;
                end
                CMD_RD: if (evt_ap) slot_d.vld = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= '0;
        else        slot_q <= slot_d;
    end

    assign open_vld = slot_q.vld;
    assign open_row = slot_q.row;
    assign pre_ok   = (slot_q.ras == '0) && (slot_q.wrc == '0);

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
    import ddr_seq_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int ROW_W     = 13,
    parameter  int CFG_W     = 3,
    parameter  int ATP_W     = 4,
    localparam int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            evt_vld,
    input  ddr_cmd_e                        evt_cmd,
    input  logic [BA_W-1:0]                 evt_bank,
    input  logic [ROW_W-1:0]                evt_row,
    input  logic                            evt_ap,
    input  logic [ATP_W-1:0]                cfg_atp,
    input  logic [CFG_W-1:0]                cfg_wr,
    output logic [NUM_BANKS-1:0]            open_vld,
    output logic [NUM_BANKS-1:0][ROW_W-1:0] open_row,
    output logic [NUM_BANKS-1:0]            pre_ok
);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ddr_bank_slot #(
            .ROW_W(ROW_W),
            .CFG_W(CFG_W),
            .ATP_W(ATP_W)
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt_sel (evt_vld && (evt_bank == BA_W'(b))),
            .evt_cmd (evt_cmd),
            .evt_row (evt_row),
            .evt_ap  (evt_ap),
            .cfg_atp (cfg_atp),
            .cfg_wr  (cfg_wr),
            .open_vld(open_vld[b]),
            .open_row(open_row[b]),
            .pre_ok  (pre_ok[b])
        );
    end

endmodule

// File: rtl/ddr_txn_seq.sv
module ddr_txn_seq
    import ddr_seq_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int ROW_W     = 13,
    parameter  int COL_W     = 10,
    parameter  int WORDS_W   = 5,
    parameter  int CFG_W     = 3,
    parameter  int ATP_W     = 4,
    parameter  int AP_BIT    = 10,
    localparam int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [BA_W-1:0]    req_bank,
    input  logic [ROW_W-1:0]   req_row,
    input  logic [COL_W-1:0]   req_col,
    input  logic [WORDS_W-1:0] req_words,
    input  logic [CFG_W-1:0]   cfg_rp,
    input  logic [CFG_W-1:0]   cfg_rcd,
    input  logic [CFG_W-1:0]   cfg_wr,
    input  logic [ATP_W-1:0]   cfg_atp,
    input  logic               cfg_ap_en,
    output logic               busy,
    output logic               cs_n,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic [BA_W-1:0]    ba,
    output logic [ROW_W-1:0]   addr
);

    localparam int PAIR_W = WORDS_W - 1;

    typedef struct packed {
        seq_st_e             st;
        logic [CFG_W-1:0]    cnt;
        logic [PAIR_W-1:0]   idx;
        logic [PAIR_W-1:0]   pairs;
        logic                wr;
        logic [BA_W-1:0]     bank;
        logic [ROW_W-1:0]    row;
        logic [COL_W-1:0]    col;
        logic                cs_n;
        ddr_cmd_e            cmd;
        logic [BA_W-1:0]     ba;
        logic [ROW_W-1:0]    addr;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NUM_BANKS-1:0]            open_vld;
    logic [NUM_BANKS-1:0][ROW_W-1:0] open_row;
    logic [NUM_BANKS-1:0]            pre_ok;

    logic             row_hit, do_pre, do_act, do_col, last_col;
    logic [COL_W-1:0] col_cur;

    assign row_hit  = open_vld[seq_q.bank] && (open_row[seq_q.bank] == seq_q.row);
    assign last_col = (seq_q.idx == seq_q.pairs - 1'b1);
    assign col_cur  = seq_q.col + COL_W'({seq_q.idx, 1'b0});

    always_comb begin
        seq_d      = seq_q;
        seq_d.cs_n = 1'b1;
        seq_d.cmd  = CMD_NOP;
        seq_d.ba   = '0;
        seq_d.addr = '0;
        do_pre     = 1'b0;
        do_act     = 1'b0;
        do_col     = 1'b0;

        case (seq_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.st    = ST_START;
                    seq_d.wr    = req_write;
                    seq_d.bank  = req_bank;
                    seq_d.row   = req_row;
                    seq_d.col   = req_col;
                    seq_d.pairs = req_words[WORDS_W-1:1];
                    seq_d.idx   = '0;
                end
            end
            ST_START: begin
                if (row_hit)                      do_col = 1'b1;
                else if (!open_vld[seq_q.bank])   do_act = 1'b1;
                else if (pre_ok[seq_q.bank])      do_pre = 1'b1;
            end
            ST_WACT: begin
                if (seq_q.cnt == '0) do_act = 1'b1;
                else begin
                    seq_d.cs_n = 1'b0;
                    seq_d.cnt  = seq_q.cnt - 1'b1;
                end
            end
            ST_WCOL: begin
                if (seq_q.cnt == '0) do_col = 1'b1;
                else begin
                    seq_d.cs_n = 1'b0;
                    seq_d.cnt  = seq_q.cnt - 1'b1;
                end
            end
            ST_COL: do_col = 1'b1;
            ST_TAIL: begin
                seq_d.cs_n = 1'b0;
                seq_d.st   = ST_IDLE;
            end
            default: seq_d.st = ST_IDLE;
        endcase

        if (do_pre) begin
            seq_d.cs_n = 1'b0;
            seq_d.cmd  = CMD_PRE;
            seq_d.ba   = seq_q.bank;
            seq_d.cnt  = cfg_rp - 1'b1;
            seq_d.st   = ST_WACT;
        end
        if (do_act) begin
            seq_d.cs_n = 1'b0;
            seq_d.cmd  = CMD_ACT;
            seq_d.ba   = seq_q.bank;
            seq_d.addr = seq_q.row;
            seq_d.cnt  = cfg_rcd - 1'b1;
            seq_d.st   = ST_WCOL;
        end
        if (do_col) begin
            seq_d.cs_n         = 1'b0;
            seq_d.cmd          = seq_q.wr ? CMD_WR : CMD_RD;
            seq_d.ba           = seq_q.bank;
            seq_d.addr         = ROW_W'(col_cur);
            seq_d.addr[AP_BIT] = cfg_ap_en && last_col;
            seq_d.idx          = seq_q.idx + 1'b1;
            seq_d.st           = last_col ? ST_TAIL : ST_COL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= ST_IDLE;
            seq_q.cs_n <= 1'b1;
            seq_q.cmd  <= CMD_NOP;
        end else begin
            seq_q <= seq_d;
        end
    end

    ddr_bank_tracker #(
        .NUM_BANKS(NUM_BANKS),
        .ROW_W    (ROW_W),
        .CFG_W    (CFG_W),
        .ATP_W    (ATP_W)
    ) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_vld (!seq_d.cs_n && (seq_d.cmd != CMD_NOP)),
        .evt_cmd (seq_d.cmd),
        .evt_bank(seq_d.ba),
        .evt_row (seq_d.addr),
        .evt_ap  (seq_d.addr[AP_BIT]),
        .cfg_atp (cfg_atp),
        .cfg_wr  (cfg_wr),
        .open_vld(open_vld),
        .open_row(open_row),
        .pre_ok  (pre_ok)
    );

    assign busy  = (seq_q.st != ST_IDLE);
    assign cs_n  = seq_q.cs_n;
    assign ras_n = seq_q.cmd[2];
    assign cas_n = seq_q.cmd[1];
    assign we_n  = seq_q.cmd[0];
    assign ba    = seq_q.ba;
    assign addr  = seq_q.addr;

endmodule

// File: rtl/ddr_txn_seq_chk.sv
module ddr_txn_seq_chk
    import ddr_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CFG_W     = 3,
    parameter int ATP_W     = 4,
    parameter int BA_W      = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic [BA_W-1:0]  ba,
    input logic             addr_ap,
    input logic [CFG_W-1:0] cfg_rp,
    input logic [CFG_W-1:0] cfg_rcd,
    input logic [CFG_W-1:0] cfg_wr,
    input logic [ATP_W-1:0] cfg_atp
);

    localparam int CW = ATP_W + 1;

    logic [2:0] cmd;
    logic       is_pre, is_act, is_col, is_wr, is_nop_sel;

    assign cmd        = {ras_n, cas_n, we_n};
    assign is_pre     = !cs_n && (cmd == CMD_PRE);
    assign is_act     = !cs_n && (cmd == CMD_ACT);
    assign is_wr      = !cs_n && (cmd == CMD_WR);
    assign is_col     = !cs_n && ((cmd == CMD_WR) || (cmd == CMD_RD));
    assign is_nop_sel = !cs_n && (cmd == CMD_NOP);

    logic [CW-1:0] since_act [NUM_BANKS];
    logic [CW-1:0] since_wr  [NUM_BANKS];

    always_ff @(posedge clk or negedge rst_n) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!rst_n) begin
                since_act[b] <= '1;
                since_wr[b]  <= '1;
            end else begin
                if (is_act && (ba == BA_W'(b)))  since_act[b] <= CW'(1);
                else if (since_act[b] != '1)     since_act[b] <= since_act[b] + 1'b1;
                if (is_wr && (ba == BA_W'(b)))   since_wr[b]  <= CW'(1);
                else if (since_wr[b] != '1)      since_wr[b]  <= since_wr[b] + 1'b1;
            end
        end
    end

    // R11
    desel_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (cmd == CMD_NOP));

    // R11
    first_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (cmd != CMD_NOP));

    // R2
    pre_single_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> !addr_ap);

    // R2
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |=> ((cfg_rp == CFG_W'(1)) ? is_act : is_nop_sel));

    // R5
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |=> ((cfg_rcd == CFG_W'(1)) ? is_col : is_nop_sel));

    // R9
    atp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (since_act[ba] >= CW'(cfg_atp)));

    // R10
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (since_wr[ba] >= CW'(cfg_wr) + CW'(1)));

endmodule

bind ddr_txn_seq ddr_txn_seq_chk #(
    .NUM_BANKS(NUM_BANKS),
    .CFG_W    (CFG_W),
    .ATP_W    (ATP_W),
    .BA_W     (BA_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .ba     (ba),
    .addr_ap(addr[AP_BIT]),
    .cfg_rp (cfg_rp),
    .cfg_rcd(cfg_rcd),
    .cfg_wr (cfg_wr),
    .cfg_atp(cfg_atp)
);

// File: tb/ddr_txn_seq_tb.sv
module ddr_txn_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_PRE = 3'b010, C_ACT = 3'b011, C_WR = 3'b100,
                           C_RD = 3'b101, C_NOP = 3'b111;

    logic        clk, rst_n;
    logic        req_valid, req_write, cfg_ap_en;
    logic [1:0]  req_bank;
    logic [12:0] req_row;
    logic [9:0]  req_col;
    logic [4:0]  req_words;
    logic [2:0]  cfg_rp, cfg_rcd, cfg_wr;
    logic [3:0]  cfg_atp;
    logic        busy, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] addr;

    int n_chk = 0;
    int n_bad = 0;

    ddr_txn_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_words(req_words), .cfg_rp(cfg_rp), .cfg_rcd(cfg_rcd),
        .cfg_wr(cfg_wr), .cfg_atp(cfg_atp), .cfg_ap_en(cfg_ap_en),
        .busy(busy), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .ba(ba), .addr(addr)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // write, bank, row, col, words, ap, rp, rcd, entry (0 hit, 1 closed, 2 miss)
    typedef struct packed {
        logic        w;
        logic [1:0]  bk;
        logic [12:0] row;
        logic [9:0]  col;
        logic [4:0]  words;
        logic        ap;
        logic [2:0]  rp;
        logic [2:0]  rcd;
        logic [1:0]  entry;
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 2'd0, 13'h0010, 10'h020, 5'd2, 1'b0, 3'd2, 3'd2, 2'd1},
        '{1'b0, 2'd0, 13'h0010, 10'h040, 5'd4, 1'b0, 3'd1, 3'd1, 2'd0},
        '{1'b1, 2'd0, 13'h0022, 10'h008, 5'd4, 1'b0, 3'd2, 3'd3, 2'd2},
        '{1'b1, 2'd2, 13'h0033, 10'h000, 5'd8, 1'b0, 3'd4, 3'd4, 2'd1},
        '{1'b0, 2'd2, 13'h0033, 10'h010, 5'd2, 1'b1, 3'd3, 3'd1, 2'd0},
        '{1'b0, 2'd2, 13'h0033, 10'h012, 5'd4, 1'b0, 3'd1, 3'd2, 2'd1},
        '{1'b1, 2'd3, 13'h1FFF, 10'h3F8, 5'd4, 1'b0, 3'd1, 3'd1, 2'd1},
        '{1'b0, 2'd0, 13'h0022, 10'h030, 5'd6, 1'b1, 3'd1, 3'd1, 2'd0},
        '{1'b0, 2'd0, 13'h0005, 10'h000, 5'd2, 1'b0, 3'd2, 3'd1, 2'd1},
        '{1'b0, 2'd3, 13'h0000, 10'h100, 5'd2, 1'b0, 3'd1, 3'd4, 2'd2},
        '{1'b1, 2'd1, 13'h00AA, 10'h004, 5'd2, 1'b1, 3'd4, 3'd1, 2'd1}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_bus(input string tag, input logic exp_cs, input logic [2:0] exp_cmd,
                           input logic [1:0] exp_ba, input bit use_ba,
                           input logic [12:0] exp_addr, input logic [12:0] mask);
        logic [18:0] a, e;
        a = {cs_n, ras_n, cas_n, we_n, use_ba ? ba : 2'd0, addr & mask};
        e = {exp_cs, exp_cmd, use_ba ? exp_ba : 2'd0, exp_addr & mask};
        chk(a == e, tag, "{cs,cmd,ba,addr}", 32'(a), 32'(e));
    endtask

    task automatic run_txn(input logic w, input logic [1:0] bk, input logic [12:0] row,
                           input logic [9:0] col, input logic [4:0] words, input logic ap,
                           input logic [2:0] rp, input logic [2:0] rcd, input int entry,
                           input int stall, input int gap, input string ftag);
        string t;
        int    np;
        repeat (gap) @(negedge clk);
        cfg_rp = rp; cfg_rcd = rcd; cfg_ap_en = ap;
        req_valid = 1'b1; req_write = w; req_bank = bk; req_row = row;
        req_col = col; req_words = words;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R11", "busy after accept", 32'(busy), 32'd1);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            chk_bus(ftag, 1'b1, C_NOP, 2'd0, 1'b0, 13'd0, 13'd0);
        end
        if (entry == 2) begin
            @(negedge clk);
            t = (ftag != "") ? ftag : "R2";
            chk_bus(t, 1'b0, C_PRE, bk, 1'b1, 13'd0, 13'h0400);
            for (int i = 1; i < int'(rp); i++) begin
                @(negedge clk);
                chk_bus("R2", 1'b0, C_NOP, 2'd0, 1'b0, 13'd0, 13'd0);
            end
        end
        if (entry >= 1) begin
            @(negedge clk);
            t = (entry == 2) ? "R2" : ((ftag != "") ? ftag : "R3");
            chk_bus(t, 1'b0, C_ACT, bk, 1'b1, row, 13'h1FFF);
            for (int i = 1; i < int'(rcd); i++) begin
                @(negedge clk);
                chk_bus("R5", 1'b0, C_NOP, 2'd0, 1'b0, 13'd0, 13'd0);
            end
        end
        np = int'(words) / 2;
        for (int i = 0; i < np; i++) begin
            logic [12:0] ea;
            @(negedge clk);
            ea = {3'b000, col + 10'(2 * i)};
            ea[10] = ap && (i == np - 1);
            if (i == 0 && entry == 0) t = (ftag != "") ? ftag : "R4";
            else if (i == 0 && entry >= 1) t = "R5";
            else t = (i == np - 1) ? "R7" : "R6";
            chk_bus(t, 1'b0, w ? C_WR : C_RD, bk, 1'b1, ea, 13'h1FFF);
        end
        @(negedge clk);
        chk_bus("R11", 1'b0, C_NOP, 2'd0, 1'b0, 13'd0, 13'd0);
        @(negedge clk);
        chk_bus("R11", 1'b1, C_NOP, 2'd0, 1'b0, 13'd0, 13'd0);
        chk(busy == 1'b0, "R11", "busy after tail", 32'(busy), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog: actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_bank = '0;
        req_row = '0; req_col = '0; req_words = 5'd2;
        cfg_rp = 3'd1; cfg_rcd = 3'd1; cfg_wr = 3'd4; cfg_atp = 4'd8; cfg_ap_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state at the pins
        chk_bus("R1", 1'b1, C_NOP, 2'd0, 1'b0, 13'd0, 13'd0);
        chk(busy == 1'b0, "R1", "busy in reset", 32'(busy), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_bus("R1", 1'b1, C_NOP, 2'd0, 1'b0, 13'd0, 13'd0);

        // table: R1 first access closed, R8 after auto-precharge
        for (int v = 0; v < NVEC; v++) begin
            string ft;
            ft = (v == 0) ? "R1" : ((v == 5 || v == 8) ? "R8" : "");
            run_txn(VEC[v].w, VEC[v].bk, VEC[v].row, VEC[v].col, VEC[v].words,
                    VEC[v].ap, VEC[v].rp, VEC[v].rcd, int'(VEC[v].entry), 0, 12, ft);
        end

        // R9: activate-to-precharge hold with cfg_atp = 8, then 5
        cfg_atp = 4'd8;
        run_txn(1'b0, 2'd1, 13'h040, 10'h0, 5'd2, 1'b0, 3'd1, 3'd1, 1, 0, 12, "R8");
        run_txn(1'b0, 2'd1, 13'h041, 10'h0, 5'd2, 1'b0, 3'd1, 3'd1, 2, 3, 0, "R9");
        cfg_atp = 4'd5;
        run_txn(1'b0, 2'd1, 13'h042, 10'h0, 5'd2, 1'b0, 3'd1, 3'd1, 2, 0, 12, "");
        run_txn(1'b0, 2'd1, 13'h043, 10'h0, 5'd2, 1'b0, 3'd1, 3'd1, 2, 0, 0, "R9");

        // R10: write recovery hold with cfg_wr = 4, then 1
        cfg_wr = 3'd4;
        run_txn(1'b1, 2'd1, 13'h044, 10'h0, 5'd2, 1'b0, 3'd1, 3'd1, 2, 0, 12, "");
        run_txn(1'b0, 2'd1, 13'h045, 10'h0, 5'd2, 1'b0, 3'd1, 3'd1, 2, 1, 0, "R10");
        cfg_wr = 3'd1;
        run_txn(1'b1, 2'd1, 13'h046, 10'h0, 5'd2, 1'b0, 3'd1, 3'd1, 2, 0, 12, "");
        run_txn(1'b0, 2'd1, 13'h047, 10'h0, 5'd2, 1'b0, 3'd1, 3'd1, 2, 0, 0, "R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule